// File: doc/BRIEF.md
# Fractional-N Divider Word Sequencer

This block drives the feedback divider of a fractional-N frequency synthesizer. It keeps two 16-bit divide words, one for the upper and one for the lower carrier. Each word has a 4-bit integer part and a 12-bit fraction, so one fraction step equals the reference frequency over 4096. Software writes the word bytes into staging registers through a byte-wide write port. Nothing reaches the divider until a load bit in the control register commits both words together. At commit time each word is clamped into the range the modulator can handle safely.

On every reference clock the block picks a committed word. The choice depends on the modulation mode and the transmit data bit. The block emits an integer divide count equal to the word's integer part plus a fixed 16, plus the output of a second-order MASH 1-1 delta-sigma modulator. The modulator output averages to the fraction. When both committed fractions are zero the modulator is kept idle and the count is a pure integer. A ready flag reports when a new setting has had time to settle. A status nibble shows the integer part of the word in use.

Top module: `fracn_word_seq`

## Requirements
- R1: Bits [15:12] of a divide word are its integer part and bits [11:0] its fraction. Output `int_nibble` shows bits [15:12] of the selected word, one clock after the selection changes.
- R2: While the modulator is active, `div_count` equals 16 plus the selected integer part plus an offset. The offset always lies between -1 and +2.
- R3: With a fixed selected fraction F, the offsets summed over any 4096 consecutive cycles differ from F by at most 1.
- R4: With mode bit 0 (ASK), the low word is selected whatever `tx_data` is. With mode bit 1 (FSK), the high word is selected when `tx_data` is 1 and the low word when it is 0.
- R5: Addresses 1 and 2 stage the high word's bits [15:8] and [7:0]. Addresses 3 and 4 stage the low word's bits [15:8] and [7:0]. Staged bytes have no effect on any output until a load.
- R6: At address 0, bit 0 is the mode (1 = FSK) and takes effect with the write. Bit 1 is the load bit. Writing 1 to it commits both staged words on the next clock, after which the pending load clears by itself.
- R7: At commit, a staged word below 0x2F42 becomes 0x2F42 and a staged word above 0xC05A becomes 0xC05A.
- R8: When both committed fractions are zero, `mod_active` is 0 and `div_count` equals exactly 16 plus the selected integer part on every cycle. Otherwise `mod_active` is 1.
- R9: `ready` is 0 while a load is pending. It rises READY_CYCLES+1 clocks after the clock edge that wrote the load bit, and likewise READY_CYCLES clocks after reset.
- R10: After reset the high word is DEF_HI (0x6000), the low word is DEF_LO (0x5000), the mode is ASK and `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one divider cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| tx_data | input | 1 | Transmit data bit used for the FSK word choice |
| div_count | output | DIV_W | Integer divide count for this reference cycle |
| mod_active | output | 1 | Delta-sigma modulator running |
| ready | output | 1 | Committed setting has settled |
| int_nibble | output | 4 | Integer part of the selected word |

## Verification
The divide count is exercised with three kinds of word pairs. Integer-only pairs must give a constant count with the modulator off. Fractions near zero, mid-range and near full scale must give 4096-cycle offset sums that separate a correct MASH average from a wrong carry or a missing stage. Out-of-range pairs must show clamping through the status nibble. Switching the mode and the data bit with different high and low integer parts reveals a swapped or mis-gated selection. Staging bytes without a load, and then counting clocks to the ready edge, shows whether the commit gating and the settle delay are correct.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int WORD_W     = 16;
  localparam int FRAC_W     = 12;
  localparam int INT_W      = WORD_W - FRAC_W;
  localparam int INT_OFFSET = 16;
  localparam int ADDR_W     = 3;
  localparam int BYTE_W     = 8;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t WORD_MIN = 16'h2F42;
  localparam word_t WORD_MAX = 16'hC05A;

  function automatic word_t clamp_word(input word_t w);
    if (w < WORD_MIN)      return WORD_MIN;
    else if (w > WORD_MAX) return WORD_MAX;
    else                   return w;
  endfunction
endpackage

// File: rtl/fracn_regs.sv
module fracn_regs
  import fracn_pkg::*;
#(
  parameter int    READY_CYCLES = 8,
  parameter word_t DEF_HI       = 16'h6000,
  parameter word_t DEF_LO       = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output word_t             hi_word,
  output word_t             lo_word,
  output logic              mode_fsk,
  output logic              ready
);
  localparam int CNT_W = $clog2(READY_CYCLES + 1);

  word_t            stage_hi, stage_lo;
  logic             pend;
  logic [CNT_W-1:0] settle_cnt;
  logic             load_wr;

  assign load_wr = wr_en && (wr_addr == ADDR_W'(0)) && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_hi   <= DEF_HI;
      stage_lo   <= DEF_LO;
      hi_word    <= DEF_HI;
      lo_word    <= DEF_LO;
      mode_fsk   <= 1'b0;
      pend       <= 1'b0;
      settle_cnt <= CNT_W'(READY_CYCLES);
      ready      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(0): mode_fsk       <= wr_data[0];
          ADDR_W'(1): stage_hi[15:8] <= wr_data;
          ADDR_W'(2): stage_hi[7:0]  <= wr_data;
          ADDR_W'(3): stage_lo[15:8] <= wr_data;
          ADDR_W'(4): stage_lo[7:0]  <= wr_data;
          default: ;
        endcase
      end
      if (load_wr) begin
        pend  <= 1'b1;
        ready <= 1'b0;
      end else if (pend) begin
        pend       <= 1'b0;
        hi_word    <= clamp_word(stage_hi);
        lo_word    <= clamp_word(stage_lo);
        settle_cnt <= CNT_W'(READY_CYCLES);
        ready      <= 1'b0;
      end else if (settle_cnt != '0) begin
        settle_cnt <= settle_cnt - CNT_W'(1);
        ready      <= (settle_cnt == CNT_W'(1));
      end
    end
  end

  // R7: committed words never leave the safe window
  a_r7_hi_in_range: assert property (@(posedge clk) disable iff (rst)
    hi_word >= WORD_MIN && hi_word <= WORD_MAX);
  a_r7_lo_in_range: assert property (@(posedge clk) disable iff (rst)
    lo_word >= WORD_MIN && lo_word <= WORD_MAX);
  // R6: a pending load clears itself unless re-requested
  a_r6_load_selfclear: assert property (@(posedge clk) disable iff (rst)
    pend && !load_wr |=> !pend);
  // R9: not ready while a load waits
  a_r9_not_ready_pending: assert property (@(posedge clk) disable iff (rst)
    pend |-> !ready);
  // R5: committed words move only through a pending load
  a_r5_words_hold: assert property (@(posedge clk) disable iff (rst)
    !pend |=> $stable(hi_word) && $stable(lo_word));
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [FRAC_W-1:0] frac,
  output logic signed [2:0] offset
);
  logic [FRAC_W-1:0] acc1, acc2;
  logic              c2_d;
  logic [FRAC_W:0]   sum1, sum2;

  assign sum1 = {1'b0, acc1} + {1'b0, frac};
  assign sum2 = {1'b0, acc2} + {1'b0, sum1[FRAC_W-1:0]};

  always_comb begin
    if (enable)
      offset = $signed({2'b00, sum1[FRAC_W]}) + $signed({2'b00, sum2[FRAC_W]})
             - $signed({2'b00, c2_d});
    else
      offset = 3'sd0;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      acc1 <= '0;
      acc2 <= '0;
      c2_d <= 1'b0;
    end else begin
      acc1 <= sum1[FRAC_W-1:0];
      acc2 <= sum2[FRAC_W-1:0];
      c2_d <= sum2[FRAC_W];
    end
  end

  // R8: an idle modulator leaves its state cleared
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !enable |=> acc1 == '0 && acc2 == '0 && !c2_d);
endmodule

// File: rtl/fracn_word_seq.sv
module fracn_word_seq
  import fracn_pkg::*;
#(
  parameter int    READY_CYCLES = 8,
  parameter int    DIV_W        = 6,
  parameter word_t DEF_HI       = 16'h6000,
  parameter word_t DEF_LO       = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tx_data,
  output logic [DIV_W-1:0]  div_count,
  output logic              mod_active,
  output logic              ready,
  output logic [3:0]        int_nibble
);
  word_t             hi_word, lo_word, sel_word;
  logic              mode_fsk, frac_en;
  logic signed [2:0] offset;
  logic [DIV_W-1:0]  base_cnt;

  fracn_regs #(
    .READY_CYCLES(READY_CYCLES),
    .DEF_HI      (DEF_HI),
    .DEF_LO      (DEF_LO)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hi_word (hi_word),
    .lo_word (lo_word),
    .mode_fsk(mode_fsk),
    .ready   (ready)
  );

  assign sel_word = (mode_fsk && tx_data) ? hi_word : lo_word;
  assign frac_en  = (hi_word[FRAC_W-1:0] != '0) || (lo_word[FRAC_W-1:0] != '0);
  assign base_cnt = DIV_W'(INT_OFFSET) + DIV_W'(sel_word[WORD_W-1:FRAC_W]);

  fracn_mash #(.FRAC_W(FRAC_W)) u_mash (
    .clk   (clk),
    .rst   (rst),
    .enable(frac_en),
    .frac  (sel_word[FRAC_W-1:0]),
    .offset(offset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_count  <= DIV_W'(INT_OFFSET) + DIV_W'(DEF_LO[WORD_W-1:FRAC_W]);
      mod_active <= 1'b0;
      int_nibble <= DEF_LO[WORD_W-1:FRAC_W];
    end else begin
      div_count  <= base_cnt + {{(DIV_W-3){offset[2]}}, offset};
      mod_active <= frac_en;
      int_nibble <= sel_word[WORD_W-1:FRAC_W];
    end
  end

  // R8: with the modulator off the count is the bare integer ratio
  a_r8_bypass_exact: assert property (@(posedge clk) disable iff (rst)
    !mod_active |-> int'(div_count) == INT_OFFSET + int'(int_nibble));
  // R2: count stays within the modulator's offset window
  a_r2_offset_window: assert property (@(posedge clk) disable iff (rst)
    int'(div_count) >= INT_OFFSET + int'(int_nibble) - 1 &&
    int'(div_count) <= INT_OFFSET + int'(int_nibble) + 2);
  // R4: ASK mode always reports the low word
  a_r4_ask_low: assert property (@(posedge clk) disable iff (rst)
    !mode_fsk |=> int_nibble == $past(lo_word[WORD_W-1:FRAC_W]));
endmodule

// File: tb/fracn_word_seq_bench.sv
module fracn_word_seq_bench;
  localparam int RDY = 8;
  localparam int DW  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          tx_data = 1'b0;
  logic [DW-1:0] div_count;
  logic          mod_active, ready;
  logic [3:0]    int_nibble;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  fracn_word_seq #(.READY_CYCLES(RDY), .DIV_W(DW)) u_fracn_word_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_data(tx_data), .div_count(div_count), .mod_active(mod_active),
    .ready(ready), .int_nibble(int_nibble)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stage(input logic [15:0] hi, input logic [15:0] lo);
    wr(3'd1, hi[15:8]); wr(3'd2, hi[7:0]);
    wr(3'd3, lo[15:8]); wr(3'd4, lo[7:0]);
  endtask

  task automatic commit(input logic fsk);
    wr(3'd0, {6'd0, 1'b1, fsk});
    repeat (RDY + 3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(ready == 1'b0, "R10 ready after reset", ready, 0);
    chk(int_nibble == 4'h5, "R10 low word default", int_nibble, 5);
    chk(mod_active == 1'b0, "R10 modulator off", mod_active, 0);
    chk(div_count == DW'(21), "R10 default count", div_count, 21);
    repeat (RDY) @(negedge clk);
    chk(ready == 1'b1, "R9 ready after reset delay", ready, 1);
  endtask

  task automatic t_ask_ignores_data;
    tx_data = 1'b1; @(negedge clk); @(negedge clk);
    chk(int_nibble == 4'h5, "R4 ASK ignores data=1", int_nibble, 5);
    tx_data = 1'b0; @(negedge clk); @(negedge clk);
    chk(int_nibble == 4'h5, "R4 ASK data=0", int_nibble, 5);
  endtask

  task automatic t_fsk_select;
    stage(16'h9000, 16'h7000); commit(1'b1);
    tx_data = 1'b1; @(negedge clk); @(negedge clk);
    chk(int_nibble == 4'h9, "R4 FSK data=1 high word", int_nibble, 9);
    chk(div_count == DW'(25), "R1 count high word", div_count, 25);
    tx_data = 1'b0; @(negedge clk); @(negedge clk);
    chk(int_nibble == 4'h7, "R4 FSK data=0 low word", int_nibble, 7);
    wr(3'd0, 8'h00); @(negedge clk);
    tx_data = 1'b1; @(negedge clk); @(negedge clk);
    chk(int_nibble == 4'h7, "R6 mode write to ASK at once", int_nibble, 7);
  endtask

  task automatic t_bypass;
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (div_count != DW'(23) || mod_active) bad++;
    end
    chk(bad == 0, "R8 integer-only constant count", bad, 0);
  endtask

  task automatic t_staging_no_effect;
    tx_data = 1'b0;
    stage(16'hA000, 16'hB000);
    repeat (RDY + 4) @(negedge clk);
    chk(int_nibble == 4'h7, "R5 staged bytes held back", int_nibble, 7);
    chk(ready == 1'b1, "R5 ready unaffected by staging", ready, 1);
  endtask

  task automatic t_ready_timing;
    int low_bad = 0;
    wr(3'd0, 8'h02);
    chk(ready == 1'b0, "R9 ready drops on load", ready, 0);
    for (int i = 0; i < RDY; i++) begin
      if (ready) low_bad++;
      @(negedge clk);
    end
    chk(low_bad == 0 && ready == 1'b0, "R9 ready held low", low_bad, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R9 ready rises on time", ready, 1);
    chk(int_nibble == 4'hB, "R6 load committed low word", int_nibble, 11);
  endtask

  task automatic t_average(input logic [15:0] lo);
    int sum = 0, bad = 0, base;
    stage(16'h6000, lo); commit(1'b0);
    base = 16 + int'(lo[15:12]);
    chk(mod_active == 1'b1, "R8 modulator on with fraction", mod_active, 1);
    for (int i = 0; i < 4096; i++) begin
      int d;
      @(negedge clk);
      d = int'(div_count) - base;
      if (d < -1 || d > 2) bad++;
      sum += d;
    end
    chk(bad == 0, "R2 offset within -1..+2", bad, 0);
    chk(sum >= int'(lo[11:0]) - 1 && sum <= int'(lo[11:0]) + 1,
        "R3 offset average equals fraction", sum, int'(lo[11:0]));
  endtask

  task automatic t_clamp;
    stage(16'hFFFF, 16'h1000); commit(1'b1);
    tx_data = 1'b0; @(negedge clk); @(negedge clk);
    chk(int_nibble == 4'h2, "R7 low word clamped up", int_nibble, 2);
    chk(mod_active == 1'b1, "R7 clamped fraction nonzero", mod_active, 1);
    tx_data = 1'b1; @(negedge clk); @(negedge clk);
    chk(int_nibble == 4'hC, "R7 high word clamped down", int_nibble, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ask_ignores_data();
    t_fsk_select();
    t_bypass();
    t_staging_no_effect();
    t_ready_timing();
    t_average(16'h5123);
    t_average(16'h5001);
    t_average(16'h5FFF);
    t_clamp();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    vectors++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule